// File: doc/BRIEF.md
# Split Instruction/Data Memory Port

This block is the memory side of a microcoded datapath. Each microinstruction can raise three request bits: a word read, a word write and an instruction-byte fetch. The data side moves 32-bit words between the memory data register it owns and a word-addressed store, using the word address on the `mar` input. The instruction side loads one byte, addressed by the byte address on the `pc` input, into the byte register it owns. The two sides run at the same time, so a fetch can accompany a read or a write.

Each request is issued in one cycle (one microinstruction) and completes at the clock edge that ends the next cycle. The address and write data are captured at the issuing edge, so later changes on the inputs cannot disturb a pending access. The block holds one parameterized store with a write port and two read ports, one per side. The fetch side sees the same words as a byte view. The store can be cleared by reset. Each side is a small state machine. The data side has the states `D_IDLE`, `D_READ` and `D_WRITE`. The instruction side has the states `I_IDLE` and `I_FETCH`.

The data side's next state is taken from the request bits every cycle: `mem_rd` leads to `D_READ`, otherwise `mem_wr` leads to `D_WRITE`, otherwise the side goes to `D_IDLE`. `ifetch` leads to `I_FETCH`, otherwise the instruction side goes to `I_IDLE`. The completion work is done in `D_READ`, `D_WRITE` and `I_FETCH`. The byte register is offered on two 32-bit views, one sign-extended and one zero-extended. A C-bus value can be loaded into either register through a load enable.

Top module: `mem_port_split`

## Requirements
- R1: The reset (active-low `rst_n`) has the following effects. `mdr` and `mbr` become 0, and both sides return to idle. With `CLEAR_ON_RESET`=1, every word of the store reads as 0 afterwards.
- R2: If `mem_wr` is high in cycle k and `mem_rd` is low, the value of `mdr` during cycle k is stored at word `mar` at the end of cycle k+1. A read issued in cycle k+1 or later returns that value.
- R3: If `mem_rd` is high in cycle k, `mdr` is loaded at the end of cycle k+1 with the word at `mar` as it was in cycle k. The new value shows on `mdr` from cycle k+2.
- R4: If `ifetch` is high in cycle k, `mbr` is loaded at the end of cycle k+1 with the byte at address `pc` as it was in cycle k. The store is little-endian: byte address 4w+i is bits [8i+7:8i] of word w.
- R5: If `mem_rd` and `mem_wr` are both high in a cycle, only the read takes place and the store is left unchanged.
- R6: A fetch can be issued in the same cycle as a read or a write, and both complete on time. A fetch that completes at the same edge as a write returns the contents from before the write.
- R7: Changes to `mar`, `pc` or `mdr` after the issuing cycle have no effect on a pending access.
- R8: A completing read takes priority over `mdr_load`. A completing fetch takes priority over `mbr_load`. When no access completes, `mdr_load` loads `c_bus` into `mdr`, and `mbr_load` loads `c_bus[7:0]` into `mbr`.
- R9: `mbr_sext` is `mbr` with bit 7 copied into bits 31:8. `mbr_zext` is `mbr` with bits 31:8 set to zero.
- R10: When no access completes and its load enable is low, each register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one microinstruction per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_rd | input | 1 | Word read request |
| mem_wr | input | 1 | Word write request |
| ifetch | input | 1 | Instruction byte fetch request |
| mar | input | WORD_AW | Word address of the data access |
| pc | input | WORD_AW+2 | Byte address of the fetch |
| c_bus | input | 32 | C-bus value for register loads |
| mdr_load | input | 1 | Load `mdr` from `c_bus` |
| mbr_load | input | 1 | Load `mbr` from `c_bus[7:0]` |
| mdr | output | 32 | Memory data register |
| mbr | output | 8 | Memory byte register |
| mbr_sext | output | 32 | Sign-extended byte register |
| mbr_zext | output | 32 | Zero-extended byte register |

## Verification
Directed patterns cover the following cases:
- A write followed by a read of the same word shows that the write lands one cycle after it is issued.
- A combined read and write request separates read-wins behaviour from write-wins behaviour.
- A fetch issued together with a write to the same word shows whether the fetch sees the old or the new contents.
- Changing `mar` and `mdr` right after an issue shows whether the address and data were captured.
- Loading `mdr` while a read completes shows which source has priority.

Seeded random traffic then mixes all three requests over a few words. The addresses are chosen so that writes, reads and fetches collide often. A cycle-level reference built from the requirements compares every output every cycle.

// File: rtl/mem_port_pkg.sv
package mem_port_pkg;

    localparam int WORD_W = 32;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        D_IDLE,
        D_READ,
        D_WRITE
    } dside_e;

    typedef enum logic {
        I_IDLE,
        I_FETCH
    } iside_e;

endpackage

// File: rtl/mp_store.sv
module mp_store
    import mem_port_pkg::*;
#(
    parameter int WORD_AW        = 6,
    parameter bit CLEAR_ON_RESET = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [WORD_AW-1:0]   addr,
    input  logic [WORD_W-1:0]    wdata,
    output logic [WORD_W-1:0]    rdata,
    input  logic [WORD_AW+1:0]   faddr,
    output logic [BYTE_W-1:0]    fbyte
);

    localparam int DEPTH = 1 << WORD_AW;

    logic [WORD_W-1:0] cells [DEPTH];
    logic [WORD_W-1:0] fword;

    // Both read ports are combinational; results are registered by the sides.
    assign rdata = cells[addr];
    assign fword = cells[faddr[WORD_AW+1:2]];
    assign fbyte = fword[faddr[1:0]*BYTE_W +: BYTE_W];

    generate
        if (CLEAR_ON_RESET) begin : g_clear
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
                end else if (we) begin
                    cells[addr] <= wdata;
                end
            end
        end else begin : g_keep
            always_ff @(posedge clk) begin
                if (we) cells[addr] <= wdata;
            end
        end
    endgenerate

endmodule

// File: rtl/mp_data_side.sv
module mp_data_side
    import mem_port_pkg::*;
#(
    parameter int WORD_AW = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_req,
    input  logic                wr_req,
    input  logic [WORD_AW-1:0]  mar_in,
    input  logic                ld_en,
    input  logic [WORD_W-1:0]   cbus,
    input  logic [WORD_W-1:0]   st_rdata,
    output logic [WORD_W-1:0]   mdr_q,
    output logic                st_we,
    output logic [WORD_AW-1:0]  st_addr,
    output logic [WORD_W-1:0]   st_wdata,
    output logic                rd_done
);

    dside_e             state, state_nxt;
    logic [WORD_AW-1:0] pend_addr;
    logic [WORD_W-1:0]  pend_data;
    logic [WORD_W-1:0]  mdr_nxt;

    // State register: also captures the issue-time address and write data.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= D_IDLE;
            pend_addr <= '0;
            pend_data <= '0;
            mdr_q     <= '0;
        end else begin
            state     <= state_nxt;
            pend_addr <= mar_in;
            pend_data <= mdr_q;
            mdr_q     <= mdr_nxt;
        end
    end

    // Outputs and transitions: a read beats a write when both are requested.
    always_comb begin
        if (rd_req)      state_nxt = D_READ;
        else if (wr_req) state_nxt = D_WRITE;
        else             state_nxt = D_IDLE;

        st_we    = 1'b0;
        rd_done  = 1'b0;
        st_addr  = pend_addr;
        st_wdata = pend_data;
        mdr_nxt  = ld_en ? cbus : mdr_q;

        unique case (state)
            D_IDLE: ;
            D_READ: begin
                rd_done = 1'b1;
                mdr_nxt = st_rdata;
            end
            D_WRITE: st_we = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/mp_instr_side.sv
module mp_instr_side
    import mem_port_pkg::*;
#(
    parameter int WORD_AW = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fetch_req,
    input  logic [WORD_AW+1:0]  pc_in,
    input  logic                ld_en,
    input  logic [BYTE_W-1:0]   cbyte,
    input  logic [BYTE_W-1:0]   st_fbyte,
    output logic [BYTE_W-1:0]   mbr_q,
    output logic [WORD_AW+1:0]  st_faddr,
    output logic                fetch_done
);

    iside_e             state, state_nxt;
    logic [WORD_AW+1:0] pend_pc;
    logic [BYTE_W-1:0]  mbr_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= I_IDLE;
            pend_pc <= '0;
            mbr_q   <= '0;
        end else begin
            state   <= state_nxt;
            pend_pc <= pc_in;
            mbr_q   <= mbr_nxt;
        end
    end

    always_comb begin
        state_nxt  = fetch_req ? I_FETCH : I_IDLE;
        st_faddr   = pend_pc;
        fetch_done = 1'b0;
        mbr_nxt    = ld_en ? cbyte : mbr_q;

        unique case (state)
            I_IDLE: ;
            I_FETCH: begin
                fetch_done = 1'b1;
                mbr_nxt    = st_fbyte;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/mem_port_split.sv
module mem_port_split
    import mem_port_pkg::*;
#(
    parameter int WORD_AW        = 6,
    parameter bit CLEAR_ON_RESET = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mem_rd,
    input  logic                 mem_wr,
    input  logic                 ifetch,
    input  logic [WORD_AW-1:0]   mar,
    input  logic [WORD_AW+1:0]   pc,
    input  logic [31:0]          c_bus,
    input  logic                 mdr_load,
    input  logic                 mbr_load,
    output logic [31:0]          mdr,
    output logic [7:0]           mbr,
    output logic [31:0]          mbr_sext,
    output logic [31:0]          mbr_zext
);

    localparam int PAD_W = WORD_W - BYTE_W;

    logic               mem_we;
    logic [WORD_AW-1:0] mem_addr;
    logic [WORD_W-1:0]  mem_wdata;
    logic [WORD_W-1:0]  mem_rdata;
    logic               rd_done;
    logic [WORD_AW+1:0] fetch_addr;
    logic [BYTE_W-1:0]  fetch_byte;
    logic               fetch_done;

    mp_data_side #(.WORD_AW(WORD_AW)) u_data (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_req   (mem_rd),
        .wr_req   (mem_wr),
        .mar_in   (mar),
        .ld_en    (mdr_load),
        .cbus     (c_bus),
        .st_rdata (mem_rdata),
        .mdr_q    (mdr),
        .st_we    (mem_we),
        .st_addr  (mem_addr),
        .st_wdata (mem_wdata),
        .rd_done  (rd_done)
    );

    mp_instr_side #(.WORD_AW(WORD_AW)) u_instr (
        .clk        (clk),
        .rst_n      (rst_n),
        .fetch_req  (ifetch),
        .pc_in      (pc),
        .ld_en      (mbr_load),
        .cbyte      (c_bus[BYTE_W-1:0]),
        .st_fbyte   (fetch_byte),
        .mbr_q      (mbr),
        .st_faddr   (fetch_addr),
        .fetch_done (fetch_done)
    );

    mp_store #(.WORD_AW(WORD_AW), .CLEAR_ON_RESET(CLEAR_ON_RESET)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .addr  (mem_addr),
        .wdata (mem_wdata),
        .rdata (mem_rdata),
        .faddr (fetch_addr),
        .fbyte (fetch_byte)
    );

    assign mbr_sext = {{PAD_W{mbr[BYTE_W-1]}}, mbr};
    assign mbr_zext = {{PAD_W{1'b0}}, mbr};

endmodule

// File: rtl/mem_port_split_chk.sv
module mem_port_split_chk #(
    parameter int WORD_AW = 6
) (
    input logic                clk,
    input logic                rst_n,
    input logic                mem_rd,
    input logic                mem_wr,
    input logic                ifetch,
    input logic [WORD_AW-1:0]  mar,
    input logic                mdr_load,
    input logic                mbr_load,
    input logic [31:0]         mdr,
    input logic [7:0]          mbr,
    input logic                mem_we,
    input logic [WORD_AW-1:0]  mem_addr,
    input logic [31:0]         mem_wdata,
    input logic [31:0]         mem_rdata,
    input logic                rd_done,
    input logic [7:0]          fetch_byte,
    input logic                fetch_done
);

    a_r3_read_result: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> (mdr == $past(mem_rdata)));

    a_r4_fetch_result: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_done |=> (mbr == $past(fetch_byte)));

    a_r5_read_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && mem_wr) |=> (rd_done && !mem_we));

    a_r2_write_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && !mem_rd) |=> (mem_we && mem_addr == $past(mar) && mem_wdata == $past(mdr)));

    a_r6_fetch_alongside: assert property (@(posedge clk) disable iff (!rst_n)
        (ifetch && (mem_rd || mem_wr)) |=> (fetch_done && (rd_done || mem_we)));

    a_r10_mdr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_done && !mdr_load) |=> $stable(mdr));

    a_r10_mbr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_done && !mbr_load) |=> $stable(mbr));

endmodule

bind mem_port_split mem_port_split_chk #(.WORD_AW(WORD_AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .ifetch     (ifetch),
    .mar        (mar),
    .mdr_load   (mdr_load),
    .mbr_load   (mbr_load),
    .mdr        (mdr),
    .mbr        (mbr),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_rdata  (mem_rdata),
    .rd_done    (rd_done),
    .fetch_byte (fetch_byte),
    .fetch_done (fetch_done)
);

// File: tb/mem_port_split_bench.sv
`timescale 1ns/1ps
module mem_port_split_bench;

    localparam int AW    = 6;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mem_rd = 0, mem_wr = 0, ifetch = 0;
    logic [AW-1:0] mar = '0;
    logic [AW+1:0] pc = '0;
    logic [31:0]   c_bus = '0;
    logic          mdr_load = 0, mbr_load = 0;
    logic [31:0]   mdr, mbr_sext, mbr_zext;
    logic [7:0]    mbr;

    int checks = 0;
    int fails  = 0;

    // reference state
    logic [31:0]   ref_mem [DEPTH];
    logic [31:0]   ref_mdr;
    logic [7:0]    ref_mbr;
    logic          p_rd, p_wr, p_f;
    logic [AW-1:0] p_addr;
    logic [31:0]   p_data;
    logic [AW+1:0] p_pc;

    always #4 clk = ~clk;

    mem_port_split #(.WORD_AW(AW), .CLEAR_ON_RESET(1'b1)) u_mem_port_split (
        .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .mem_wr(mem_wr), .ifetch(ifetch),
        .mar(mar), .pc(pc), .c_bus(c_bus), .mdr_load(mdr_load), .mbr_load(mbr_load),
        .mdr(mdr), .mbr(mbr), .mbr_sext(mbr_sext), .mbr_zext(mbr_zext)
    );

    function automatic logic [7:0] byte_at(logic [31:0] w, logic [1:0] lane);
        return w[lane*8 +: 8];
    endfunction

    function automatic logic [31:0] sext8(logic [7:0] b);
        return {{24{b[7]}}, b};
    endfunction

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        check(tag, "mdr", mdr, ref_mdr);
        check(tag, "mbr", {24'b0, mbr}, {24'b0, ref_mbr});
        check(tag, "mbr_sext R9", mbr_sext, sext8(ref_mbr));
        check(tag, "mbr_zext R9", mbr_zext, {24'b0, ref_mbr});
    endtask

    // Reference update for one clock edge, from the requirements.
    task automatic model_edge();
        logic [31:0] n_mdr;
        logic [7:0]  n_mbr;
        n_mdr = p_rd ? ref_mem[p_addr] : (mdr_load ? c_bus : ref_mdr);
        n_mbr = p_f ? byte_at(ref_mem[p_pc[AW+1:2]], p_pc[1:0])
                    : (mbr_load ? c_bus[7:0] : ref_mbr);
        if (p_wr) ref_mem[p_addr] = p_data;
        p_rd   = mem_rd;
        p_wr   = mem_wr && !mem_rd;
        p_f    = ifetch;
        p_addr = mar;
        p_data = ref_mdr;
        p_pc   = pc;
        ref_mdr = n_mdr;
        ref_mbr = n_mbr;
    endtask

    // Called at a falling edge: drive, run one cycle, compare at next falling edge.
    task automatic cyc(string tag, logic rd, logic wr, logic f, logic [AW-1:0] a,
                       logic [AW+1:0] p, logic [31:0] cb, logic lm, logic lb);
        mem_rd = rd; mem_wr = wr; ifetch = f; mar = a; pc = p;
        c_bus = cb; mdr_load = lm; mbr_load = lb;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check_all(tag);
    endtask

    task automatic idle(string tag);
        cyc(tag, 0, 0, 0, '0, '0, 32'h0, 0, 0);
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
        ref_mdr = '0; ref_mbr = '0;
        p_rd = 0; p_wr = 0; p_f = 0; p_addr = '0; p_data = '0; p_pc = '0;
        void'($urandom(32'd20240607));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_all("R1 reset");

        // R1: cleared store reads zero, fetch returns zero
        cyc("R1", 0, 0, 0, 6'd0, 8'd0, 32'hFFFF_FFFF, 1, 1);
        cyc("R1", 1, 0, 1, 6'd5, 8'd22, 32'h0, 0, 0);
        idle("R1");

        // R2 / R4: write a word then read it back, fetch each lane
        cyc("R2", 0, 0, 0, 6'd0, 8'd0, 32'h8A4B_C2D1, 1, 0);
        cyc("R2", 0, 1, 0, 6'd3, 8'd0, 32'h0, 0, 0);
        cyc("R2", 1, 0, 0, 6'd3, 8'd0, 32'h0, 0, 0);
        idle("R2");
        for (int lane = 0; lane < 4; lane++) begin
            cyc("R4", 0, 0, 1, 6'd0, 8'(12 + lane), 32'h0, 0, 0);
            idle("R4");
        end

        // R5: read and write together, store must keep the old word
        cyc("R5", 0, 0, 0, 6'd0, 8'd0, 32'h1111_2222, 1, 0);
        cyc("R5", 1, 1, 0, 6'd3, 8'd0, 32'h0, 0, 0);
        idle("R5");
        cyc("R5", 1, 0, 0, 6'd3, 8'd0, 32'h0, 0, 0);
        idle("R5");

        // R6: fetch alongside a write to the same word sees pre-write contents
        cyc("R6", 0, 0, 0, 6'd0, 8'd0, 32'h7E00_F055, 1, 0);
        cyc("R6", 0, 1, 1, 6'd3, 8'd12, 32'h0, 0, 0);
        idle("R6");
        cyc("R6", 1, 0, 1, 6'd3, 8'd13, 32'h0, 0, 0);
        idle("R6");

        // R7: inputs change right after issue
        cyc("R7", 0, 0, 0, 6'd0, 8'd0, 32'hCAFE_0001, 1, 0);
        cyc("R7", 0, 1, 1, 6'd9, 8'd13, 32'h0, 0, 0);
        cyc("R7", 0, 0, 0, 6'd10, 8'd40, 32'hDEAD_0002, 1, 0);
        cyc("R7", 1, 0, 0, 6'd9, 8'd0, 32'h0, 0, 0);
        cyc("R7", 1, 0, 0, 6'd10, 8'd0, 32'h0, 0, 0);
        idle("R7");

        // R8: completion beats the C-bus load on both registers
        cyc("R8", 1, 0, 1, 6'd9, 8'd36, 32'h0, 0, 0);
        cyc("R8", 0, 0, 0, 6'd0, 8'd0, 32'h5555_AAAA, 1, 1);
        cyc("R8", 0, 0, 0, 6'd0, 8'd0, 32'h0000_0080, 1, 1);

        // R10: hold with nothing pending
        idle("R10");
        idle("R10");

        // R9 and mixed traffic
        for (int n = 0; n < 3000; n++) begin
            cyc("RND R3 R4", 1'($urandom % 3 == 0), 1'($urandom % 3 == 0),
                1'($urandom % 2), 6'($urandom % 8), 8'($urandom % 32),
                $urandom, 1'($urandom % 4 == 0), 1'($urandom % 4 == 0));
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule